// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block watches a processor for signs of life. Software writes an 8-bit control value that sets a timeout: a 5-bit multiplier times one of four resolutions. Either edge of the watchdog input pin restarts the countdown. A write of the control value also restarts it. If neither happens in time, the block raises a watchdog flag. It then either asserts an interrupt or drives an active-low reset pulse of fixed length, as a steering bit selects.

Time comes from a 16 Hz tick-enable input, so each resolution is a whole number of ticks. A reset-pulse expiry clears the block's own control value when the pulse ends. In the same cycle it sends a one-cycle strobe that clears related enable bits held elsewhere. Power-down disables the timer and clears its control value.

Top module: `wdog_steer`

## Requirements
- R1: After reset, `irq` is 0, `rst_out_n` is 1, `ctl_clr` is 0, `wdf` is 0 and `reg_q` is 00h.
- R2: The control value holds the steering bit in bit 7, the multiplier M in bits 6:2 and the resolution code in bits 1:0. The timeout is M×1, M×4, M×16 or M×64 ticks for codes 00, 01, 10 and 11. Expiry happens on the tick that ends the count, so 0Eh expires on the 48th tick.
- R3: A multiplier of zero disables the timer, so no expiry ever occurs.
- R4: A rising or a falling edge on `wdi` restarts the full timeout. `wdi` passes through two synchronising flops, so an edge takes effect within three clocks.
- R5: A write of the control value restarts the full timeout with the new value.
- R6: On expiry `wdf` is set. A pulse on `flag_rd` clears it; if expiry and `flag_rd` fall in the same cycle, the flag is set.
- R7: With bit 7 at 0, expiry sets `irq`. A read of the flag and a nonzero write both leave `irq` set. Only a write of 00h clears it, and that write also disables the timer.
- R8: With bit 7 at 1, expiry drives `rst_out_n` low for exactly TREC_CLKS clocks and leaves `irq` at 0. In the first cycle after the pulse, `ctl_clr` is 1 for one clock and `reg_q` reads 00h.
- R9: `pwr_down` clears the control value, stops the countdown, clears `irq` and ends any reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-clock enable at 16 Hz |
| reg_wr | input | 1 | Write strobe for the control value |
| reg_wdata | input | 8 | Control value to write |
| wdi | input | 1 | Watchdog input pin, asynchronous |
| flag_rd | input | 1 | Flag-register read strobe, clears the flag |
| pwr_down | input | 1 | Power-down indication |
| irq | output | 1 | Interrupt request, active high |
| rst_out_n | output | 1 | Reset pulse, active low |
| ctl_clr | output | 1 | One-cycle strobe clearing external enable bits |
| wdf | output | 1 | Watchdog flag |
| reg_q | output | 8 | Current control value |

## Verification
The bench counts ticks up to the boundary of each resolution: one tick short must leave the outputs quiet, and the final tick must fire. A design that scales a resolution wrongly, or that is off by one tick, therefore shows a visible difference. The bench restarts the timer just before expiry with a rising edge of `wdi`, then with a falling edge, then with a write. A design that detects only one edge direction, or that does not reload on a write, fires early. The bench also checks that the interrupt survives a flag read and a nonzero write, that a multiplier of zero never fires, and that power-down clears a pending interrupt. It measures the reset pulse width and the timing of the clear strobe cycle by cycle, so a pulse that is off by one clock or a strobe that comes early is reported.

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int TREC_CLKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       wdi,
  input  logic       flag_rd,
  input  logic       pwr_down,
  output logic       irq,
  output logic       rst_out_n,
  output logic       ctl_clr,
  output logic       wdf,
  output logic [7:0] reg_q
);
  localparam int CNT_W = 11;
  localparam int PW = $clog2(TREC_CLKS + 1);

  logic [7:0]       wreg;
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pulse;
  logic [2:0]       wsync;
  logic             irq_q, wdf_q, clr_q;

  function automatic logic [CNT_W-1:0] ticks_of(input logic [7:0] v);
    return CNT_W'(v[6:2]) << {v[1:0], 1'b0};
  endfunction

  wire wdi_edge = wsync[2] ^ wsync[1];
  wire reload   = reg_wr | wdi_edge;
  wire [CNT_W-1:0] load_val = reg_wr ? ticks_of(reg_wdata) : ticks_of(wreg);
  wire expire   = tick16 && (cnt == CNT_W'(1)) && !reload && !pwr_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wreg  <= '0;
      cnt   <= '0;
      pulse <= '0;
      wsync <= '0;
      irq_q <= 1'b0;
      wdf_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      wsync <= {wsync[1:0], wdi};
      clr_q <= 1'b0;
      if (expire)       wdf_q <= 1'b1;
      else if (flag_rd) wdf_q <= 1'b0;
      if (pwr_down) begin
        wreg  <= '0;
        cnt   <= '0;
        pulse <= '0;
        irq_q <= 1'b0;
      end else begin
        if (reg_wr) wreg <= reg_wdata;
        if (reload) cnt <= load_val;
        else if (tick16 && cnt != '0) cnt <= cnt - 1'b1;
        if (reg_wr && reg_wdata == 8'h00) irq_q <= 1'b0;
        else if (expire && !wreg[7])      irq_q <= 1'b1;
        if (expire && wreg[7]) pulse <= PW'(TREC_CLKS);
        else if (pulse != '0) begin
          pulse <= pulse - 1'b1;
          if (pulse == PW'(1)) begin
            wreg  <= '0;
            cnt   <= '0;
            clr_q <= 1'b1;
          end
        end
      end
    end
  end

  assign irq       = irq_q;
  assign rst_out_n = (pulse == '0);
  assign ctl_clr   = clr_q;
  assign wdf       = wdf_q;
  assign reg_q     = wreg;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       pwr_down,
  input logic       irq,
  input logic       rst_out_n,
  input logic       ctl_clr,
  input logic       wdf,
  input logic [7:0] reg_q
);
  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata == 8'h00) |=> !irq);
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(pwr_down || (reg_wr && reg_wdata == 8'h00)));
  // R6
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> wdf);
  // R8
  clr_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_clr) |-> (reg_q == 8'h00) && rst_out_n && $past(!rst_out_n));
  // R8
  pulse_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> !$rose(irq));
  // R9
  pwr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (reg_q == 8'h00) && !irq && rst_out_n);
endmodule

bind wdog_steer wdog_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .pwr_down(pwr_down), .irq(irq), .rst_out_n(rst_out_n),
  .ctl_clr(ctl_clr), .wdf(wdf), .reg_q(reg_q)
);

// File: tb/wdog_steer_tb.sv
`timescale 1ns/1ps
module wdog_steer_tb;
  localparam int TREC = 16;
  logic clk = 0, rst_n = 0, tick16 = 0, reg_wr = 0, wdi = 0, flag_rd = 0, pwr_down = 0;
  logic [7:0] reg_wdata = 0;
  logic irq, rst_out_n, ctl_clr, wdf;
  logic [7:0] reg_q;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  wdog_steer #(.TREC_CLKS(TREC)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick16 = 1; @(negedge clk); tick16 = 0; @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr = 1; reg_wdata = v; @(negedge clk); reg_wr = 0;
  endtask

  task automatic rdflag;
    flag_rd = 1; @(negedge clk); flag_rd = 0;
  endtask

  task automatic timeout_case(input logic [7:0] v, input int n, input string req);
    wr(8'h00); rdflag();
    wr(v);
    ticks(n - 1);
    chk({req, " early"}, {irq, wdf}, 2'b00);
    ticks(1);
    chk({req, " expiry"}, {irq, wdf}, 2'b11);
    wr(8'h00); rdflag();
  endtask

  task automatic t_reset;
    chk("R1 outputs", {irq, rst_out_n, ctl_clr, wdf}, 4'b0100);
    chk("R1 reg", reg_q, 8'h00);
  endtask

  task automatic t_resolutions;
    timeout_case({1'b0, 5'd3, 2'b00}, 3, "R2 res0");
    timeout_case({1'b0, 5'd2, 2'b01}, 8, "R2 res1");
    timeout_case({1'b0, 5'd1, 2'b10}, 16, "R2 res2");
    timeout_case({1'b0, 5'd1, 2'b11}, 64, "R2 res3");
    timeout_case(8'h0E, 48, "R2 0Eh");
  endtask

  task automatic t_zero_mult;
    wr({1'b0, 5'd0, 2'b11});
    ticks(100);
    chk("R3 no expiry", {irq, wdf}, 2'b00);
    wr(8'h00);
  endtask

  task automatic t_wdi;
    wr({1'b0, 5'd4, 2'b00});
    ticks(3);
    wdi = 1; clocks(4);
    ticks(3);
    chk("R4 rising restart", irq, 1'b0);
    wdi = 0; clocks(4);
    ticks(3);
    chk("R4 falling restart", irq, 1'b0);
    ticks(1);
    chk("R4 expiry after restart", irq, 1'b1);
    wr(8'h00); rdflag();
  endtask

  task automatic t_write_restart;
    wr({1'b0, 5'd4, 2'b00});
    ticks(3);
    wr({1'b0, 5'd2, 2'b00});
    ticks(1);
    chk("R5 restart early", irq, 1'b0);
    ticks(1);
    chk("R5 new value expiry", irq, 1'b1);
    wr(8'h00); rdflag();
  endtask

  task automatic t_irq_flag;
    wr({1'b0, 5'd1, 2'b00});
    ticks(1);
    chk("R6 flag set", wdf, 1'b1);
    rdflag();
    chk("R6 flag cleared", wdf, 1'b0);
    chk("R7 irq survives read", irq, 1'b1);
    wr({1'b0, 5'd5, 2'b00});
    chk("R7 irq survives nonzero write", irq, 1'b1);
    wr(8'h00);
    chk("R7 irq cleared by 00h", irq, 1'b0);
    ticks(20);
    chk("R7 disabled after 00h", {irq, wdf}, 2'b00);
  endtask

  task automatic t_pulse;
    int low;
    int clr_seen;
    low = 0;
    clr_seen = 0;
    wr({1'b1, 5'd1, 2'b00});
    ticks(1);
    chk("R8 pulse asserted", rst_out_n, 1'b0);
    chk("R8 no irq", irq, 1'b0);
    chk("R8 flag", wdf, 1'b1);
    low = 1;
    while (!rst_out_n && low < 100) begin
      chk("R8 no strobe during pulse", ctl_clr, 1'b0);
      @(negedge clk); low++;
    end
    chk("R8 pulse width", low - 1, TREC - 1 + 0);
    chk("R8 strobe", ctl_clr, 1'b1);
    chk("R8 reg cleared", reg_q, 8'h00);
    @(negedge clk);
    if (ctl_clr) clr_seen = 1;
    chk("R8 strobe one cycle", clr_seen, 0);
    rdflag();
  endtask

  task automatic t_pwr_down;
    wr({1'b0, 5'd1, 2'b00});
    ticks(1);
    chk("R9 irq before", irq, 1'b1);
    pwr_down = 1; @(negedge clk); pwr_down = 0;
    chk("R9 irq cleared", irq, 1'b0);
    chk("R9 reg cleared", reg_q, 8'h00);
    rdflag();
    wr({1'b0, 5'd2, 2'b00});
    ticks(1);
    pwr_down = 1; @(negedge clk); pwr_down = 0;
    ticks(10);
    chk("R9 countdown stopped", {irq, wdf}, 2'b00);
  endtask

  initial begin
    fork
      begin
        clocks(3);
        t_reset();
        rst_n = 1;
        clocks(2);
        t_reset();
        t_resolutions();
        t_zero_mult();
        t_wdi();
        t_write_restart();
        t_irq_flag();
        t_pulse();
        t_pwr_down();
      end
      begin
        clocks(150000);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule